// File: doc/BRIEF.md
# Limit-Wrap Interval Timer

This block is a two-channel interval timer on a simple word-addressed register port. A shared prescaler divides the system clock into a one-cycle tick once per microsecond. Each channel holds a 21-bit counter and a 21-bit limit. On every tick an enabled channel either steps its counter up by one or, when the step would reach the limit, wraps the counter back to 1 and raises a sticky limit-reached flag. That flag is the channel's interrupt line. Because the wrap restarts at 1, a period of N ticks is programmed as a limit of N+1.

Software acknowledges the interrupt by reading or writing the channel's ordinary limit register. A second, alias limit register loads a new limit without touching the flag. Any limit load, through either register, zeroes the counter, so the first tick after the load shows 1. A limit of zero parks the channel. Each channel also has a small read/write control word that powers up as 1.

Top module: `lwt_timer`

## Requirements
- R1: A tick occurs once every PRESCALE clock cycles, the first on the PRESCALE-th rising edge after reset release. Counters change only on a tick or on a limit load.
- R2: On a tick with a nonzero limit L, if count+1 >= L the count becomes 1 and the flag sets. Otherwise the count increments. With L >= 2 the count runs 1..L-1, and with L = 1 it reads 1 and the flag sets on every tick.
- R3: A count or limit word carries the flag in bit 31 and the value in bits 30:10, and bits 9:0 read as zero. A limit write takes only bits 30:10 of the write data.
- R4: The word address `addr` selects registers as follows: 0 = channel A count, 1 = A limit, 2 = channel B count, 3 = B limit, 4 = A alias limit, 5 = B alias limit, 6 = A control, 7 = B control. Writes to a count address are ignored.
- R5: `irq_a` and `irq_b` equal their channel's flag. The flag stays set until software clears it.
- R6: A read of a channel's ordinary limit address clears its flag on that edge. If a wrap happens on the same edge, the flag stays set.
- R7: A write to the ordinary limit address loads the limit, clears the flag and zeroes the count.
- R8: A write to the alias limit address loads the limit and zeroes the count, and leaves the flag unchanged. A read of the alias address returns the limit word and does not clear the flag.
- R9: A channel whose limit is zero holds its count and never sets its flag.
- R10: After reset each limit value is 10000 (the word reads 0x009c4000), each count is 0, each flag is 0 and each control word reads 1.
- R11: An access to one channel's registers never changes the other channel's count, limit, flag or control word.
- R12: The control word stores write data bits CTL_W-1:0 and reads back with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| rd_en | input | 1 | Register read strobe; enables the read side effect |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_a | output | 1 | Channel A limit-reached interrupt |
| irq_b | output | 1 | Channel B limit-reached interrupt |

## Verification
A wrap that sets a flag can fall on the same edge as a read of that channel's ordinary limit register, which clears the flag. The bench keeps its own model of prescaler phase, counts and limits. It waits until the model says the next edge completes a period, then presents the limit read on exactly that cycle. The word read back must show the pre-edge flag. Afterwards the flag and its interrupt line must still be set, which confirms that the set wins over the acknowledge.

// File: rtl/lwt_pkg.sv
`timescale 1ns/1ps
package lwt_pkg;
  localparam int WORD_W   = 32;
  localparam int VAL_LSB  = 10;
  localparam int VAL_MSB  = 30;
  localparam int VAL_W    = VAL_MSB - VAL_LSB + 1;
  localparam int FLAG_BIT = 31;
  localparam int ADDR_W   = 3;
  localparam int NUM_CH   = 2;

  typedef logic [VAL_W-1:0]  val_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // per-channel strobes from the bus decode
  typedef struct packed {
    logic lim_wr;   // any limit load (ordinary or alias)
    logic lim_clr;  // the load came through the ordinary register
    logic rd_clr;   // ordinary limit read: acknowledge
    logic ctl_wr;   // control word write
  } ch_cmd_t;

  localparam word_t RST_LIM_WORD = 32'h009c_4000;

  function automatic val_t val_of(input word_t w);
    return w[VAL_MSB:VAL_LSB];
  endfunction

  function automatic word_t pack_word(input logic flag, input val_t v);
    return {flag, v, {VAL_LSB{1'b0}}};
  endfunction

  localparam val_t RST_LIM_VAL = val_of(RST_LIM_WORD);

  // true when the next step reaches or passes the limit
  function automatic logic hits_limit(input val_t cnt, input val_t lim);
    logic [VAL_W:0] nxt;
    nxt = {1'b0, cnt} + (VAL_W+1)'(1);
    return nxt >= {1'b0, lim};
  endfunction

  function automatic val_t step_count(input val_t cnt, input val_t lim);
    return hits_limit(cnt, lim) ? val_t'(1) : cnt + val_t'(1);
  endfunction

  function automatic addr_t cnt_addr(input int c);
    return addr_t'(2 * c);
  endfunction
  function automatic addr_t lim_addr(input int c);
    return addr_t'(2 * c + 1);
  endfunction
  function automatic addr_t alias_addr(input int c);
    return addr_t'(2 * NUM_CH + c);
  endfunction
  function automatic addr_t ctl_addr(input int c);
    return addr_t'(3 * NUM_CH + c);
  endfunction
endpackage

// File: rtl/lwt_prescaler.sv
`timescale 1ns/1ps
module lwt_prescaler #(
  parameter int PRESCALE = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] phase_q;
      logic          last_phase;

      assign last_phase = (phase_q == PW'(PRESCALE - 1));
      assign tick       = last_phase;

      always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= '0;
        else if (last_phase) phase_q <= '0;
        else                 phase_q <= phase_q + PW'(1);
      end

      // R1: ticks never come back to back when dividing
      assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_pass
      assign tick = rst_n;
    end
  endgenerate
endmodule

// File: rtl/lwt_channel.sv
`timescale 1ns/1ps
module lwt_channel
  import lwt_pkg::*;
#(
  parameter int CTL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ch_cmd_t          cmd,
  input  val_t             wr_val,
  input  logic [CTL_W-1:0] ctl_wdata,
  output val_t             cnt,
  output val_t             lim,
  output logic             flag,
  output logic [CTL_W-1:0] ctl
);
  val_t             cnt_q;
  val_t             lim_q;
  logic             flag_q;
  logic [CTL_W-1:0] ctl_q;

  // named internal events
  logic enabled;
  logic step_evt;
  logic wrap_evt;
  logic ack_evt;

  assign enabled  = (lim_q != '0);
  assign step_evt = tick && enabled && !cmd.lim_wr;
  assign wrap_evt = step_evt && hits_limit(cnt_q, lim_q);
  assign ack_evt  = (cmd.lim_wr && cmd.lim_clr) || cmd.rd_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= RST_LIM_VAL;
    end else if (cmd.lim_wr) begin
      cnt_q <= '0;
      lim_q <= wr_val;
    end else if (step_evt) begin
      cnt_q <= step_count(cnt_q, lim_q);
    end
  end

  // a wrap outranks an acknowledge on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap_evt) flag_q <= 1'b1;
    else if (ack_evt)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ctl_q <= CTL_W'(1);
    else if (cmd.ctl_wr) ctl_q <= ctl_wdata;
  end

  assign cnt  = cnt_q;
  assign lim  = lim_q;
  assign flag = flag_q;
  assign ctl  = ctl_q;

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |-> (cnt_q <= lim_q));

  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == val_t'(1) && flag_q));

  assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cmd.lim_wr) |=> $stable(cnt_q));

  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !cmd.lim_wr) |=> ($stable(cnt_q) && !$rose(flag_q)));

  assert_alias_keeps_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && cmd.lim_wr && !cmd.lim_clr) |=> flag_q);

  assert_read_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.rd_clr && !wrap_evt) |=> !flag_q);

  assert_wrap_beats_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.rd_clr && wrap_evt) |=> flag_q);

  assert_load_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.lim_wr |=> (cnt_q == '0 && lim_q == $past(wr_val)));
endmodule

// File: rtl/lwt_bus_decode.sv
`timescale 1ns/1ps
module lwt_bus_decode
  import lwt_pkg::*;
#(
  parameter int CTL_W = 4
) (
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  addr_t                        addr,
  input  word_t                        wdata,
  input  val_t    [NUM_CH-1:0]         cnt_all,
  input  val_t    [NUM_CH-1:0]         lim_all,
  input  logic    [NUM_CH-1:0]         flag_all,
  input  logic    [NUM_CH-1:0][CTL_W-1:0] ctl_all,
  output ch_cmd_t [NUM_CH-1:0]         cmd_all,
  output val_t                         wr_val,
  output logic    [CTL_W-1:0]          ctl_wdata,
  output word_t                        rdata
);
  logic read_only;
  logic unused_wbits;

  assign read_only    = rd_en && !wr_en;
  assign wr_val       = val_of(wdata);
  assign ctl_wdata    = wdata[CTL_W-1:0];
  assign unused_wbits = ^{wdata[FLAG_BIT], wdata[VAL_LSB-1:0]};

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit_lim;
      logic hit_alias;
      assign hit_lim   = (addr == lim_addr(c));
      assign hit_alias = (addr == alias_addr(c));

      assign cmd_all[c].lim_wr  = wr_en && (hit_lim || hit_alias);
      assign cmd_all[c].lim_clr = wr_en && hit_lim;
      assign cmd_all[c].rd_clr  = read_only && hit_lim;
      assign cmd_all[c].ctl_wr  = wr_en && (addr == ctl_addr(c));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == cnt_addr(c))
        rdata = pack_word(flag_all[c], cnt_all[c]);
      if (addr == lim_addr(c) || addr == alias_addr(c))
        rdata = pack_word(flag_all[c], lim_all[c]);
      if (addr == ctl_addr(c))
        rdata = {{(WORD_W-CTL_W){1'b0}}, ctl_all[c]};
    end
  end

  logic [3*NUM_CH-1:0] strobes;
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      strobes[3*c]   = cmd_all[c].lim_wr;
      strobes[3*c+1] = cmd_all[c].rd_clr;
      strobes[3*c+2] = cmd_all[c].ctl_wr;
    end
  end

  // R4, R11: one access reaches at most one register of one channel
  always_comb begin
    assert_one_target_R11: assert ($onehot0(strobes));
  end
endmodule

// File: rtl/lwt_timer.sv
`timescale 1ns/1ps
module lwt_timer
  import lwt_pkg::*;
#(
  parameter int PRESCALE = 50,
  parameter int CTL_W    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_a,
  output logic        irq_b
);
  logic                          tick;
  ch_cmd_t [NUM_CH-1:0]          cmd_all;
  val_t    [NUM_CH-1:0]          cnt_all;
  val_t    [NUM_CH-1:0]          lim_all;
  logic    [NUM_CH-1:0]          flag_all;
  logic    [NUM_CH-1:0][CTL_W-1:0] ctl_all;
  val_t                          wr_val;
  logic    [CTL_W-1:0]           ctl_wdata;

  lwt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  lwt_bus_decode #(.CTL_W(CTL_W)) u_dec (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cnt_all   (cnt_all),
    .lim_all   (lim_all),
    .flag_all  (flag_all),
    .ctl_all   (ctl_all),
    .cmd_all   (cmd_all),
    .wr_val    (wr_val),
    .ctl_wdata (ctl_wdata),
    .rdata     (rdata)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      lwt_channel #(.CTL_W(CTL_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd       (cmd_all[c]),
        .wr_val    (wr_val),
        .ctl_wdata (ctl_wdata),
        .cnt       (cnt_all[c]),
        .lim       (lim_all[c]),
        .flag      (flag_all[c]),
        .ctl       (ctl_all[c])
      );
    end
  endgenerate

  assign irq_a = flag_all[0];
  assign irq_b = flag_all[1];

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a && !(rd_en && !wr_en && addr == 3'd1) && !(wr_en && addr == 3'd1)) |=> irq_a);
endmodule

// File: tb/test_lwt_timer.sv
`timescale 1ns/1ps
module test_lwt_timer;
  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_a, irq_b;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lwt_timer #(.PRESCALE(PRE), .CTL_W(4)) i_lwt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
  );

  // reference model built from the requirements
  int m_pre;
  int m_cnt[2];
  int m_lim[2];
  bit m_flag[2];
  int m_ctl[2];

  always @(posedge clk) begin
    bit tk, ld_ord, ld_al, rd_ord, wrap;
    if (!rst_n) begin
      m_pre <= 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] <= 0; m_lim[c] <= 10000; m_flag[c] <= 1'b0; m_ctl[c] <= 1;
      end
    end else begin
      tk = (m_pre == PRE - 1);
      m_pre <= tk ? 0 : m_pre + 1;
      for (int c = 0; c < 2; c++) begin
        ld_ord = wr_en && addr == 3'(2*c+1);
        ld_al  = wr_en && addr == 3'(4+c);
        rd_ord = rd_en && !wr_en && addr == 3'(2*c+1);
        wrap   = 1'b0;
        if (ld_ord || ld_al) begin
          m_lim[c] <= int'(wdata[30:10]);
          m_cnt[c] <= 0;
        end else if (tk && m_lim[c] != 0) begin
          if (m_cnt[c] + 1 >= m_lim[c]) begin wrap = 1'b1; m_cnt[c] <= 1; end
          else m_cnt[c] <= m_cnt[c] + 1;
        end
        if (wrap) m_flag[c] <= 1'b1;
        else if (ld_ord || rd_ord) m_flag[c] <= 1'b0;
        if (wr_en && addr == 3'(6+c)) m_ctl[c] <= int'(wdata[3:0]);
      end
    end
  end

  function automatic logic [31:0] model_word(input logic [2:0] a);
    int c;
    c = (a < 4) ? int'(a) / 2 : ((a < 6) ? int'(a) - 4 : int'(a) - 6);
    if (a >= 6) return 32'(m_ctl[c]);
    if (a < 4 && a[0] == 1'b0) return {m_flag[c], 21'(m_cnt[c]), 10'b0};
    return {m_flag[c], 21'(m_lim[c]), 10'b0};
  endfunction

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    #5;
    if (rst_n && !done) begin
      if (rd_en) begin
        n_vec++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL scoreboard: read with no expectation, rdata=%h expected none", rdata);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
          end
        end
      end
      n_vec++;
      if (irq_a !== m_flag[0] || irq_b !== m_flag[1]) begin
        n_fail++;
        $display("FAIL R5 irq lines: actual %b%b expected %b%b", irq_a, irq_b, m_flag[0], m_flag[1]);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
  endtask

  task automatic read_lit(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic read_model(input logic [2:0] a, input string tag);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = a;
    exp_q.push_back(model_word(a)); tag_q.push_back(tag);
  endtask

  task automatic read_on_wrap(input int ch, input string tag);
    bit hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (m_pre == PRE - 1 && m_lim[ch] != 0 && m_cnt[ch] + 1 >= m_lim[ch]) begin
        rd_en = 1'b1; addr = 3'(2*ch+1);
        exp_q.push_back(model_word(addr)); tag_q.push_back(tag);
        hit = 1'b1;
      end else begin
        rd_en = 1'b0;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset values
    read_lit(3'd0, 32'h0000_0000, "R10 A count after reset");
    read_lit(3'd1, 32'h009c_4000, "R10 A limit after reset");
    read_lit(3'd3, 32'h009c_4000, "R10 B limit after reset");
    read_lit(3'd6, 32'h0000_0001, "R10 A control after reset");
    read_lit(3'd7, 32'h0000_0001, "R10 B control after reset");

    // R7, R1, R2: limit 6 on A, watch the count sequence and tick spacing
    bus_write(3'd1, 32'(6) << 10);
    read_lit(3'd0, 32'h0000_0000, "R7 A count zeroed by load");
    for (int i = 0; i < 40; i++) read_model(3'd0, "R2 A count sequence");

    // R6: acknowledge by reading the ordinary limit
    while (!m_flag[0]) idle(1);
    read_model(3'd1, "R6 A limit read returns flag");
    read_model(3'd0, "R6 A flag cleared by read");

    // R3: field extraction on writes
    bus_write(3'd3, 32'hFFFF_FFFF);
    read_lit(3'd5, 32'h7FFF_FC00, "R3 B limit field only");
    bus_write(3'd3, 32'h8000_0000 | (32'(9) << 10) | 32'h3FF);
    read_model(3'd5, "R3 B limit ignores flag and low bits");

    // R4: count writes ignored
    bus_write(3'd0, 32'h1234_5400);
    read_model(3'd0, "R4 A count write ignored");
    read_model(3'd4, "R4 A alias reads limit");

    // R8: alias load keeps the flag
    while (!m_flag[0]) idle(1);
    bus_write(3'd4, 32'(10) << 10);
    read_model(3'd0, "R8 A flag kept by alias load");
    read_model(3'd4, "R8 alias read returns limit");
    read_model(3'd0, "R8 flag kept after alias read");
    read_model(3'd1, "R8 ordinary read acknowledges");

    // R6: wrap and acknowledge on the same edge
    read_on_wrap(0, "R6 read on wrap edge");
    read_model(3'd0, "R6 wrap outranks acknowledge");
    read_on_wrap(1, "R6 read on wrap edge B");
    read_model(3'd2, "R6 wrap outranks acknowledge B");

    // R9: zero limit parks channel B
    bus_write(3'd3, 32'h0);
    idle(40);
    read_lit(3'd2, 32'h0000_0000, "R9 B count held at zero");
    read_lit(3'd3, 32'h0000_0000, "R9 B limit zero, no flag");

    // R2 corner: limit 1 wraps on every tick
    bus_write(3'd1, 32'(1) << 10);
    for (int i = 0; i < 12; i++) read_model(3'd0, "R2 A limit one");

    // R12, R11: control words
    bus_write(3'd6, 32'hFFFF_FFFF);
    read_lit(3'd6, 32'h0000_000F, "R12 A control width");
    read_lit(3'd7, 32'h0000_0001, "R11 B control untouched");
    bus_write(3'd7, 32'h0000_0006);
    read_lit(3'd7, 32'h0000_0006, "R12 B control write");

    // R11: B runs while A is loaded and acknowledged
    bus_write(3'd3, 32'(5) << 10);
    idle(9);
    bus_write(3'd1, 32'(50) << 10);
    read_model(3'd2, "R11 B count unaffected by A load");
    read_model(3'd1, "R11 A acknowledge");
    for (int i = 0; i < 20; i++) read_model(3'd2, "R11 B keeps counting");
    read_model(3'd0, "R11 A count");

    idle(4);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d reads unchecked, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule